// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block turns one request from a local master into the full command sequence that a single-beat SDRAM read or write needs. Every access starts from a closed bank: the sequencer first closes all banks, opens the addressed row, optionally waits a few idle cycles, and then issues the column command. After that it waits out a CAS latency of two and completes the data beat. The master keeps its request asserted until the sequencer answers with a one-cycle ready pulse. On a read, the data captured from the memory is presented during that pulse.

The number of idle cycles between the row-open command and the column command comes from a two-bit setting, `rcd_cfg`. It is sampled when the request is accepted. This lets the row-to-column delay be matched to the memory part and to the clock frequency.

The state machine walks these named states: `ST_IDLE` (no access, NOP on the bus), `ST_PALL` (close all banks), `ST_ACT` (open row), `ST_RWAIT` (row-to-column wait, 0 to 3 cycles), `ST_COL` (read or write command), `ST_CLAT` (latency wait), `ST_DATA` (data beat) and `ST_DONE` (ready pulse).

The transitions are:
- `ST_IDLE` to `ST_PALL` on an accepted request.
- `ST_PALL` to `ST_ACT`.
- `ST_ACT` to `ST_COL` when the wait setting is zero, otherwise to `ST_RWAIT`.
- `ST_RWAIT` stays until its counter runs out, then goes to `ST_COL`.
- `ST_COL` to `ST_CLAT` to `ST_DATA` to `ST_DONE`, and then back to `ST_IDLE`.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, ACTV=0011, READ=0101, WRIT=0100, PALL=0010. Outside an access the bus carries NOP. `sd_cke` is high at all times after reset.
- R2: A request seen while idle is accepted at that clock edge. PALL appears in the next cycle, and ACTV appears in the cycle after PALL.
- R3: During PALL, `sd_apall` is 1 and `sd_addr` is 0. During every other command, `sd_apall` is 0.
- R4: During ACTV, `sd_addr` carries the row `req_addr[COL_W +: ROW_W]` and `sd_ba` carries the bank `req_addr[ADDR_W-1 -: BANK_W]`.
- R5: With `rcd_cfg` = N (sampled at acceptance), exactly N NOP cycles lie between ACTV and the column command. For N = 0, the column command directly follows ACTV.
- R6: The column command is READ when `req_write` = 0 and WRIT when `req_write` = 1. It carries the column `req_addr[COL_W-1:0]`, zero-extended on `sd_addr`, and the bank on `sd_ba`. It is followed by exactly two NOP cycles: the latency wait and the data beat.
- R7: On a read, `sd_dq_i` is sampled at the end of the data beat and appears on `rd_data` while `req_ready` is high. `sd_dq_oe` stays low for the whole read.
- R8: On a write, from the column cycle through the data beat, `sd_dq_oe` is 1, `sd_dq_o` equals `req_wdata` and `sd_dqm` equals `~req_be`. On a read, `sd_dqm` is 0 over those cycles. At all other times `sd_dqm` is all ones and `sd_dq_oe` is 0.
- R9: `req_ready` is a single-cycle pulse in the cycle after the data beat. A request still held during that pulse is not taken again. The next acceptance happens at the earliest one idle cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | {bank, row, column}, column in the low bits |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables, active high |
| rcd_cfg | input | 2 | Row-to-column wait cycles, 0..3 |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data, valid with `req_ready` |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_dqm | output | BE_W | Byte masks, active high |
| sd_addr | output | ROW_W | Multiplexed address bus |
| sd_ba | output | BANK_W | Bank select |
| sd_apall | output | 1 | Precharge-select address line |
| sd_dq_o | output | DATA_W | Data bus output value |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_i | input | DATA_W | Data bus input value |

## Verification
The bench builds the block with ROW_W=11, COL_W=8, BANK_W=2 and DATA_W=16. The row width is therefore wider than the column width, so the zero-extension of the column onto the address bus is exercised. The address patterns set the top bank bit, the top and bottom row bits and the lowest column bit, so that any error in slicing the address is visible. All four wait settings are run for both reads and writes. Back-to-back requests check that a request held through the ready pulse is not accepted twice. The model's read data is present only during the data beat, which separates a correct sampling cycle from one cycle early.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_ACT,
        ST_RWAIT,
        ST_COL,
        ST_CLAT,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = 4'b0111;
    localparam sd_cmd_t CMD_ACTV = 4'b0011;
    localparam sd_cmd_t CMD_READ = 4'b0101;
    localparam sd_cmd_t CMD_WRIT = 4'b0100;
    localparam sd_cmd_t CMD_PALL = 4'b0010;

endpackage

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WAIT_W-1:0] rcd_cfg,
    output seq_state_e        state,
    output logic              accept,
    output logic              req_ready
);

    seq_state_e        state_q, state_d;
    logic [WAIT_W-1:0] rcd_q;
    logic [WAIT_W-1:0] wait_cnt;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign state  = state_q;

    // State register, wait counter and sampled wait setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rcd_q    <= '0;
            wait_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rcd_q <= rcd_cfg;
            end
            if (state_q == ST_ACT) begin
                wait_cnt <= rcd_q - 1'b1;
            end else if (state_q == ST_RWAIT) begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_PALL;
            ST_PALL:  state_d = ST_ACT;
            ST_ACT:   state_d = (rcd_q == '0) ? ST_COL : ST_RWAIT;
            ST_RWAIT: if (wait_cnt == '0) state_d = ST_COL;
            ST_COL:   state_d = ST_CLAT;
            ST_CLAT:  state_d = ST_DATA;
            ST_DATA:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_DONE);
    end

endmodule

// File: rtl/sdram_seq_req_reg.sv
module sdram_seq_req_reg
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int DATA_W = 16,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  seq_state_e        state,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] sd_dq_i,
    output logic              wr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sd_dq_o,
    output logic              sd_dq_oe,
    output logic [BE_W-1:0]   sd_dqm
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_q;
    logic              data_phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                wr_q    <= req_write;
            end
            if (state == ST_DATA && !wr_q) begin
                rdata_q <= sd_dq_i;
            end
        end
    end

    assign wr      = wr_q;
    assign col     = addr_q[COL_W-1:0];
    assign row     = addr_q[COL_W +: ROW_W];
    assign bank    = addr_q[ADDR_W-1 -: BANK_W];
    assign rd_data = rdata_q;

    always_comb begin
        data_phase = (state == ST_COL) || (state == ST_CLAT) || (state == ST_DATA);
        sd_dq_oe   = data_phase && wr_q;
        sd_dq_o    = sd_dq_oe ? wdata_q : '0;
        if (!data_phase) begin
            sd_dqm = '1;
        end else if (wr_q) begin
            sd_dqm = ~be_q;
        end else begin
            sd_dqm = '0;
        end
    end

endmodule

// File: rtl/sdram_seq_cmd_out.sv
module sdram_seq_cmd_out
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input  seq_state_e        state,
    input  logic              wr,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output sd_cmd_t           cmd,
    output logic              apall,
    output logic [ROW_W-1:0]  addr,
    output logic [BANK_W-1:0] ba
);

    always_comb begin
        cmd   = CMD_NOP;
        apall = 1'b0;
        addr  = '0;
        ba    = '0;
        unique case (state)
            ST_PALL: begin
                cmd   = CMD_PALL;
                apall = 1'b1;
            end
            ST_ACT: begin
                cmd  = CMD_ACTV;
                addr = row;
                ba   = bank;
            end
            ST_COL: begin
                cmd  = wr ? CMD_WRIT : CMD_READ;
                addr = ROW_W'(col);
                ba   = bank;
            end
            ST_IDLE, ST_RWAIT, ST_CLAT, ST_DATA, ST_DONE: begin
                cmd = CMD_NOP;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int DATA_W = 16,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [1:0]        rcd_cfg,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BE_W-1:0]   sd_dqm,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              sd_apall,
    output logic [DATA_W-1:0] sd_dq_o,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_i
);

    seq_state_e        state;
    logic              accept;
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    sd_cmd_t           cmd;

    sdram_seq_fsm #(.WAIT_W(2)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rcd_cfg   (rcd_cfg),
        .state     (state),
        .accept    (accept),
        .req_ready (req_ready)
    );

    sdram_seq_req_reg #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .DATA_W(DATA_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .state    (state),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .sd_dq_i  (sd_dq_i),
        .wr       (wr),
        .bank     (bank),
        .row      (row),
        .col      (col),
        .rd_data  (rd_data),
        .sd_dq_o  (sd_dq_o),
        .sd_dq_oe (sd_dq_oe),
        .sd_dqm   (sd_dqm)
    );

    sdram_seq_cmd_out #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BANK_W(BANK_W)
    ) u_cmd (
        .state(state),
        .wr   (wr),
        .bank (bank),
        .row  (row),
        .col  (col),
        .cmd  (cmd),
        .apall(sd_apall),
        .addr (sd_addr),
        .ba   (sd_ba)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = 1'b1;

endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker #(
    parameter int DATA_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_cke,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic             sd_apall,
    input logic             sd_dq_oe,
    input logic             req_ready,
    input logic [1:0]       rcd_cfg
);

    logic [3:0] pin_cmd;
    logic       is_col;
    logic       in_wait;
    logic [2:0] nop_cnt;
    logic [1:0] rcd_l;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_col  = (pin_cmd == 4'b0101) || (pin_cmd == 4'b0100);

    // Counts NOP cycles between row open and column command (R5)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_wait <= 1'b0;
            nop_cnt <= '0;
            rcd_l   <= '0;
        end else if (pin_cmd == 4'b0011) begin
            in_wait <= 1'b1;
            nop_cnt <= '0;
            rcd_l   <= rcd_cfg;
        end else if (in_wait && pin_cmd == 4'b0111) begin
            nop_cnt <= nop_cnt + 1'b1;
        end else if (is_col) begin
            in_wait <= 1'b0;
        end
    end

    a_r1_cke_high: assert property (@(posedge clk) disable iff (!rst_n) sd_cke);
    a_r2_pall_then_act: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0010) |=> (pin_cmd == 4'b0011));
    a_r3_pall_select_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0010) |-> sd_apall);
    a_r3_select_low_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != 4'b0010) |-> !sd_apall);
    a_r5_wait_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && is_col) |-> (nop_cnt == {1'b0, rcd_l}));
    a_r6_col_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |=> (pin_cmd == 4'b0111));
    a_r7_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0101) |-> !sd_dq_oe);
    a_r8_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0100) |-> sd_dq_oe);
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

endmodule

bind sdram_cmd_seq sdram_seq_checker #(.DATA_W(DATA_W)) u_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_apall (sd_apall),
    .sd_dq_oe (sd_dq_oe),
    .req_ready(req_ready),
    .rcd_cfg  (rcd_cfg)
);

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 11;
    localparam int COL_W  = 8;
    localparam int BANK_W = 2;
    localparam int DATA_W = 16;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int BE_W   = DATA_W / 8;
    localparam logic [DATA_W-1:0] JUNK = 16'hA5A5;

    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_ACTV = 4'b0011;
    localparam logic [3:0] C_READ = 4'b0101;
    localparam logic [3:0] C_WRIT = 4'b0100;
    localparam logic [3:0] C_PALL = 4'b0010;

    typedef struct {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
        logic [BE_W-1:0]   be;
        logic [1:0]        rcd;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic [1:0]        rcd_cfg = '0;
    logic              req_ready;
    logic [DATA_W-1:0] rd_data;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BE_W-1:0]   sd_dqm;
    logic [ROW_W-1:0]  sd_addr;
    logic [BANK_W-1:0] sd_ba;
    logic              sd_apall;
    logic [DATA_W-1:0] sd_dq_o;
    logic              sd_dq_oe;
    logic [DATA_W-1:0] sd_dq_i = JUNK;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];
    exp_t cur;
    int   phase = 0;
    int   nops  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_cmd_seq #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .DATA_W(DATA_W)
    ) i_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .rcd_cfg(rcd_cfg),
        .req_ready(req_ready), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_apall(sd_apall), .sd_dq_o(sd_dq_o),
        .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: queue the expected item, hold the request until ready
    task automatic drive(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                         input logic [DATA_W-1:0] rd, input logic [BE_W-1:0] be, input logic [1:0] rcd);
        exp_t e;
        e.wr = wr; e.addr = a; e.wd = wd; e.rd = rd; e.be = be; e.rcd = rcd;
        exp_q.push_back(e);
        req_write = wr; req_addr = a; req_wdata = wd; req_be = be; rcd_cfg = rcd;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
    endtask

    // Monitor: follows the command stream and compares against the queue
    always @(negedge clk) begin
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst_n) begin
            chk(sd_cke == 1'b1, "R1 cke", 32'(sd_cke), 32'd1);
            case (phase)
                0: begin
                    chk(req_ready == 1'b0, "R9 no ready while idle", 32'(req_ready), 32'd0);
                    chk(sd_dqm == '1 && !sd_dq_oe, "R8 idle masks", 32'({sd_dq_oe, sd_dqm}), 32'({1'b0, {BE_W{1'b1}}}));
                    if (c == C_PALL) begin
                        chk(sd_apall && sd_addr == '0, "R3 pall select", 32'({sd_apall, sd_addr}), 32'({1'b1, {ROW_W{1'b0}}}));
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R9 unexpected access", 32'd0, 32'd1);
                        end else begin
                            cur = exp_q.pop_front();
                        end
                        phase = 1;
                    end else begin
                        chk(c == C_NOP, "R1 idle nop", 32'(c), 32'(C_NOP));
                    end
                end
                1: begin
                    chk(c == C_ACTV, "R2 act after pall", 32'(c), 32'(C_ACTV));
                    chk(!sd_apall, "R3 select low at act", 32'(sd_apall), 32'd0);
                    chk(sd_addr == cur.addr[COL_W +: ROW_W], "R4 row", 32'(sd_addr), 32'(cur.addr[COL_W +: ROW_W]));
                    chk(sd_ba == cur.addr[ADDR_W-1 -: BANK_W], "R4 bank", 32'(sd_ba), 32'(cur.addr[ADDR_W-1 -: BANK_W]));
                    nops  = 0;
                    phase = 2;
                end
                2: begin
                    if (c == C_NOP) begin
                        nops++;
                        if (nops > 3) begin
                            chk(1'b0, "R5 wait too long", 32'(nops), 32'(cur.rcd));
                            phase = 0;
                        end
                    end else begin
                        chk(nops == int'(cur.rcd), "R5 wait cycles", 32'(nops), 32'(cur.rcd));
                        chk(c == (cur.wr ? C_WRIT : C_READ), "R6 column cmd", 32'(c), 32'(cur.wr ? C_WRIT : C_READ));
                        chk(sd_addr == ROW_W'(cur.addr[COL_W-1:0]), "R6 column", 32'(sd_addr), 32'(cur.addr[COL_W-1:0]));
                        chk(sd_ba == cur.addr[ADDR_W-1 -: BANK_W], "R6 bank", 32'(sd_ba), 32'(cur.addr[ADDR_W-1 -: BANK_W]));
                        chk(!sd_apall, "R3 select low at column", 32'(sd_apall), 32'd0);
                        phase = 3;
                    end
                end
                default: ;
            endcase
            if (phase >= 3 && phase <= 5) begin
                if (phase > 3) begin
                    chk(c == C_NOP, "R6 nop after column", 32'(c), 32'(C_NOP));
                end
                chk(req_ready == 1'b0, "R9 no early ready", 32'(req_ready), 32'd0);
                if (cur.wr) begin
                    chk(sd_dq_oe && sd_dq_o == cur.wd, "R8 write data", 32'({sd_dq_oe, sd_dq_o}), 32'({1'b1, cur.wd}));
                    chk(sd_dqm == ~cur.be, "R8 write mask", 32'(sd_dqm), 32'(~cur.be));
                end else begin
                    chk(!sd_dq_oe, "R7 no drive on read", 32'(sd_dq_oe), 32'd0);
                    chk(sd_dqm == '0, "R8 read mask", 32'(sd_dqm), 32'd0);
                end
                if (phase == 5 && !cur.wr) begin
                    sd_dq_i = cur.rd;
                end
                phase = (phase == 5) ? 6 : phase + 1;
            end else if (phase == 6) begin
                chk(req_ready == 1'b1, "R9 ready pulse", 32'(req_ready), 32'd1);
                chk(c == C_NOP, "R1 nop at ready", 32'(c), 32'(C_NOP));
                if (!cur.wr) begin
                    chk(rd_data == cur.rd, "R7 read data", 32'(rd_data), 32'(cur.rd));
                end
                chk(sd_dqm == '1 && !sd_dq_oe, "R8 released", 32'({sd_dq_oe, sd_dqm}), 32'({1'b0, {BE_W{1'b1}}}));
                sd_dq_i = JUNK;
                phase = 7;
            end else if (phase == 7) begin
                chk(c == C_NOP && !req_ready, "R9 idle gap", 32'({req_ready, c}), 32'(C_NOP));
                phase = 0;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R9 reset ready", 32'(req_ready), 32'd0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset nop",
            32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
        chk(sd_dqm == '1 && !sd_dq_oe, "R8 reset masks", 32'({sd_dq_oe, sd_dqm}), 32'({1'b0, {BE_W{1'b1}}}));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Reads, each wait setting (R5, R7)
        drive(1'b0, 21'h100001, 16'h0000, 16'h1234, 2'b11, 2'd0);
        drive(1'b0, 21'h0FFF80, 16'h0000, 16'hBEEF, 2'b11, 2'd1);
        drive(1'b0, 21'h1004FE, 16'h0000, 16'h0F0F, 2'b11, 2'd2);
        drive(1'b0, 21'h07F8FF, 16'h0000, 16'hC3C3, 2'b11, 2'd3);
        repeat (3) @(negedge clk);
        // Writes, each wait setting and byte-enable pattern (R8)
        drive(1'b1, 21'h180123, 16'h5A5A, 16'h0000, 2'b11, 2'd3);
        drive(1'b1, 21'h000001, 16'hFFFF, 16'h0000, 2'b01, 2'd0);
        drive(1'b1, 21'h1FFFFF, 16'h8001, 16'h0000, 2'b10, 2'd2);
        drive(1'b1, 21'h0AAA55, 16'h1357, 16'h0000, 2'b00, 2'd1);
        // Mixed back to back (R9)
        drive(1'b0, 21'h155500, 16'h0000, 16'h2468, 2'b11, 2'd1);
        drive(1'b1, 21'h0003FF, 16'h9ABC, 16'h0000, 2'b11, 2'd0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && phase == 0, "R2 all accesses seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R9 watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule